// File: doc/BRIEF.md
# Masked SIMD Integer Vector ALU

This block is the integer execution stage of a wide vector pipeline. It works on a 512-bit data path that is split into 16 lanes of 32 bits. Each request carries three source vectors (a, b, c), a 16-bit lane mask, the current contents of the destination vector and a 4-bit opcode. A request is accepted on any clock edge where `in_valid` is high.

Lane-wise opcodes compute one of four multiply-add forms in every enabled lane: a*b+c, a*b-c, c-a*b, or 1-a*b, which has a built-in constant. Every disabled lane returns the old destination value unchanged. Reduction opcodes collapse the enabled lanes of `src_a` into one 32-bit scalar, which is a sum, a product, a signed minimum, an OR or an AND. A scan opcode finds the lowest set bit of the scalar held in lane 0 of `src_a`.

All results are registered. They appear, with `out_valid`, on the clock edge that follows the accepting edge. They then hold until the next accepted request.

Top module: `simd_vec_alu`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R2: Opcode 0 gives, in every enabled lane, the low 32 bits of a*b plus c, wrapping modulo 2^32. Lane i occupies bits [32i+31:32i] of every vector port.
- R3: Opcode 1 gives a*b-c and opcode 2 gives c-a*b per enabled lane. Each uses the low 32 bits of the product and wraps modulo 2^32.
- R4: Opcode 3 gives 1-a*b per enabled lane, wrapping modulo 2^32, and ignores `src_c`.
- R5: For opcodes 0 to 3, a lane whose mask bit is 0 (mask bit i controls lane i) returns the matching lane of `dst_old`.
- R6: Opcodes 4 (sum, wrapping) and 5 (product, low 32 bits) reduce the enabled lanes of `src_a` into `scal_res`. For every opcode from 4 to 15, `vec_res` equals `dst_old`.
- R7: Opcode 6 gives the signed two's-complement minimum of the enabled lanes, opcode 7 gives their bitwise OR and opcode 8 gives their AND. Disabled lanes count as the identity value: 0 for sum and OR, 1 for product, 0xFFFFFFFF for AND and 0x7FFFFFFF for minimum.
- R8: Opcode 9 puts the index of the lowest set bit of `src_a[31:0]` in `scal_res[4:0]`, with the upper bits at zero, and clears `scan_zero`. If the input is zero, `scal_res` is 0 and `scan_zero` is 1. The mask has no effect on this opcode.
- R9: While `rst_n` is low at a clock edge, `out_valid`, `vec_res`, `scal_res` and `scan_zero` become 0.
- R10: Opcodes 10 to 15 are reserved. They give `scal_res` = 0 and `scan_zero` = 0. `scan_zero` is also 0 for every opcode other than 9.
- R11: A cycle with `in_valid` low leaves `vec_res`, `scal_res` and `scan_zero` unchanged, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 4 | Operation select |
| lane_mask | input | 16 | Per-lane enable, bit i for lane i |
| src_a | input | 512 | First source vector; lane 0 is the scan input |
| src_b | input | 512 | Second source vector |
| src_c | input | 512 | Addend / minuend vector |
| dst_old | input | 512 | Current destination contents |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| vec_res | output | 512 | Registered vector result |
| scal_res | output | 32 | Registered scalar result |
| scan_zero | output | 1 | Registered flag: scan input had no set bit |

## Verification
The clocked assertions assume two things about the inputs. First, they are at known values whenever `in_valid` is high. Second, the lane count is a power of two, so the reduction tree is balanced. The immediate checks inside the reduction and scan logic also assume that their inputs are defined at all times.

The bench sets every input to zero before the first edge. It changes inputs only on falling edges. It draws opcodes over the full 4-bit range, reserved codes included. Directed cases are added for an empty mask, a full mask, negative minima, wrap-around sums and scan inputs at both ends of the word.

// File: rtl/simd_alu_pkg.sv
// Package: shared opcode codes and opcode class helpers for the vector ALU.
// Assumes a 4-bit opcode; codes 10..15 are reserved.
package simd_alu_pkg;
    localparam int unsigned OP_W      = 4;
    localparam logic [3:0]  OPC_MADD  = 4'd0;
    localparam logic [3:0]  OPC_MSUB  = 4'd1;
    localparam logic [3:0]  OPC_NMSUB = 4'd2;
    localparam logic [3:0]  OPC_ONEMB = 4'd3;
    localparam logic [3:0]  OPC_RSUM  = 4'd4;
    localparam logic [3:0]  OPC_RPROD = 4'd5;
    localparam logic [3:0]  OPC_RMIN  = 4'd6;
    localparam logic [3:0]  OPC_ROR   = 4'd7;
    localparam logic [3:0]  OPC_RAND  = 4'd8;
    localparam logic [3:0]  OPC_SCAN  = 4'd9;

    typedef enum logic [1:0] {
        CLS_LANE,
        CLS_REDUCE,
        CLS_SCAN,
        CLS_NONE
    } op_class_e;

    // Map an opcode to the kind of result it produces.
    function automatic op_class_e classify(input logic [3:0] op);
        if (op <= OPC_ONEMB)     return CLS_LANE;
        else if (op <= OPC_RAND) return CLS_REDUCE;
        else if (op == OPC_SCAN) return CLS_SCAN;
        else                     return CLS_NONE;
    endfunction
endpackage

// File: rtl/lane_fma.sv
// Module: one vector lane of multiply-add variants.
// Computes a*b+c, a*b-c, c-a*b or 1-a*b on the low W bits of the product.
// It returns old_val when the lane is disabled or the opcode is not a lane op.
// Assumes the opcode codes from simd_alu_pkg.
module lane_fma
    import simd_alu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [OP_W-1:0] op,
    input  logic            en,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [W-1:0]    c,
    input  logic [W-1:0]    old_val,
    output logic [W-1:0]    res
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] prod;
    logic [W-1:0] arith;

    // Truncated product: keep the low W bits only.
    assign prod = a * b;

    // Select the multiply-add variant for this opcode.
    always_comb begin
        case (op)
            OPC_MADD:  arith = prod + c;
            OPC_MSUB:  arith = prod - c;
            OPC_NMSUB: arith = c - prod;
            OPC_ONEMB: arith = ONE - prod;
            default:   arith = old_val;
        endcase
    end

    // Predicate merge: a disabled lane keeps the destination value.
    assign res = en ? arith : old_val;
endmodule

// File: rtl/vec_reduce.sv
// Module: horizontal reduction of LANES lanes into one scalar.
// Disabled lanes are replaced by the identity value of the operation.
// A balanced binary tree then combines the lanes.
// Assumes LANES is a power of two and the opcode codes from simd_alu_pkg.
module vec_reduce
    import simd_alu_pkg::*;
#(
    parameter int unsigned LANES = 16,
    parameter int unsigned W     = 32
) (
    input  logic [OP_W-1:0]    op,
    input  logic [LANES-1:0]   mask,
    input  logic [LANES*W-1:0] vec,
    output logic [W-1:0]       root
);
    localparam int unsigned NODES = 2 * LANES - 1;
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};

    // Neutral element for each reduction kind.
    function automatic logic [W-1:0] ident(input logic [OP_W-1:0] o);
        case (o)
            OPC_RPROD: return ONE;
            OPC_RAND:  return '1;
            OPC_RMIN:  return SMAX;
            default:   return '0;
        endcase
    endfunction

    // Two-input combine step for each reduction kind.
    function automatic logic [W-1:0] combine(input logic [OP_W-1:0] o,
                                             input logic [W-1:0] x,
                                             input logic [W-1:0] y);
        case (o)
            OPC_RSUM:  return x + y;
            OPC_RPROD: return x * y;
            OPC_RMIN:  return ($signed(x) < $signed(y)) ? x : y;
            OPC_ROR:   return x | y;
            OPC_RAND:  return x & y;
            default:   return '0;
        endcase
    endfunction

    logic [W-1:0] leaf [LANES];
    logic [W-1:0] node [NODES];

    // Leaf preparation: mask each lane to its value or the identity.
    for (genvar i = 0; i < LANES; i++) begin : g_leaf
        assign leaf[i] = mask[i] ? vec[i*W +: W] : ident(op);
    end

    // Heap-ordered tree: node k combines children 2k+1 and 2k+2.
    always_comb begin
        for (int i = 0; i < int'(LANES); i++) begin
            node[int'(LANES) - 1 + i] = leaf[i];
        end
        for (int k = int'(LANES) - 2; k >= 0; k--) begin
            node[k] = combine(op, node[2*k+1], node[2*k+2]);
        end
        root = node[0];
    end

    // Result bounds: the minimum lies at or below each enabled lane,
    // and the OR result covers the bits of each enabled lane.
    always_comb begin
        for (int i = 0; i < int'(LANES); i++) begin
            if (op == OPC_RMIN && mask[i]) begin
                p_min_floor_r7: assert ($signed(root) <= $signed(vec[i*W +: W]));
            end
            if (op == OPC_ROR && mask[i]) begin
                p_or_cover_r7: assert ((root & vec[i*W +: W]) == vec[i*W +: W]);
            end
        end
    end
endmodule

// File: rtl/bit_scan.sv
// Module: find the index of the lowest set bit of a W-bit word.
// If the word is zero, the index is 0 and the zero flag is raised.
// Assumes W is at least 2.
module bit_scan #(
    parameter int unsigned W     = 32,
    parameter int unsigned IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     val,
    output logic [IDX_W-1:0] idx,
    output logic             zero
);
    // Scan downward so the last hit kept is the lowest set bit.
    always_comb begin
        idx  = '0;
        zero = 1'b1;
        for (int i = int'(W) - 1; i >= 0; i--) begin
            if (val[i]) begin
                idx  = IDX_W'(i);
                zero = 1'b0;
            end
        end
    end

    // The reported bit is set, and no bit below it is set.
    always_comb begin
        if (!zero) begin
            p_scan_hit_r8: assert (val[idx]);
            for (int j = 0; j < int'(W); j++) begin
                if (j < int'(idx)) begin
                    p_scan_lowest_r8: assert (!val[j]);
                end
            end
        end else begin
            p_scan_empty_r8: assert (val == '0 && idx == '0);
        end
    end
endmodule

// File: rtl/simd_vec_alu.sv
// Module: top of the masked SIMD integer vector ALU.
// It runs lane-wise multiply-add variants with predicate merge, horizontal
// reductions and a bit scan. All results are registered and come out with
// out_valid one cycle after the request.
// Assumes a synchronous active-low reset and inputs that are defined
// whenever in_valid is high.
module simd_vec_alu
    import simd_alu_pkg::*;
#(
    parameter int unsigned LANES  = 16,
    parameter int unsigned LANE_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [3:0]               opcode,
    input  logic [LANES-1:0]         lane_mask,
    input  logic [LANES*LANE_W-1:0]  src_a,
    input  logic [LANES*LANE_W-1:0]  src_b,
    input  logic [LANES*LANE_W-1:0]  src_c,
    input  logic [LANES*LANE_W-1:0]  dst_old,
    output logic                     out_valid,
    output logic [LANES*LANE_W-1:0]  vec_res,
    output logic [LANE_W-1:0]        scal_res,
    output logic                     scan_zero
);
    localparam int unsigned VEC_W = LANES * LANE_W;
    localparam int unsigned IDX_W = $clog2(LANE_W);

    op_class_e          cls;
    logic [VEC_W-1:0]   vec_n;
    logic [LANE_W-1:0]  red_root;
    logic [IDX_W-1:0]   scan_idx;
    logic               scan_empty;
    logic [LANE_W-1:0]  scal_n;
    logic               zero_n;

    assign cls = classify(opcode);

    // Lane array: one multiply-add unit per lane.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        lane_fma #(.W(LANE_W)) u_lane (
            .op      (opcode),
            .en      (lane_mask[i]),
            .a       (src_a[i*LANE_W +: LANE_W]),
            .b       (src_b[i*LANE_W +: LANE_W]),
            .c       (src_c[i*LANE_W +: LANE_W]),
            .old_val (dst_old[i*LANE_W +: LANE_W]),
            .res     (vec_n[i*LANE_W +: LANE_W])
        );
    end

    vec_reduce #(.LANES(LANES), .W(LANE_W)) u_reduce (
        .op   (opcode),
        .mask (lane_mask),
        .vec  (src_a),
        .root (red_root)
    );

    bit_scan #(.W(LANE_W), .IDX_W(IDX_W)) u_scan (
        .val  (src_a[LANE_W-1:0]),
        .idx  (scan_idx),
        .zero (scan_empty)
    );

    // Scalar result and zero flag, chosen by the opcode class.
    always_comb begin
        scal_n = '0;
        zero_n = 1'b0;
        case (cls)
            CLS_REDUCE: scal_n = red_root;
            CLS_SCAN: begin
                scal_n = {{(LANE_W-IDX_W){1'b0}}, scan_idx};
                zero_n = scan_empty;
            end
            default: ;
        endcase
    end

    // Output registers: load on an accepted request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            vec_res   <= '0;
            scal_res  <= '0;
            scan_zero <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                vec_res   <= vec_n;
                scal_res  <= scal_n;
                scan_zero <= zero_n;
            end
        end
    end

    // Strobe timing: the result strobe follows the request by one cycle.
    p_valid_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // Idle cycles leave every result register unchanged.
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(vec_res) && $stable(scal_res) && $stable(scan_zero)));

    // A zero flag always comes with a zero scalar.
    p_zero_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
        scan_zero |-> (scal_res == '0));

    // Non-lane opcodes pass the destination through.
    p_vec_passthru_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode > OPC_ONEMB) |=> (vec_res == $past(dst_old)));

    // Reserved opcodes give a zero scalar and a cleared flag.
    p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode > OPC_SCAN) |=> (scal_res == '0 && !scan_zero));

    // A masked-off lane returns the old destination lane.
    for (genvar i = 0; i < LANES; i++) begin : g_mask_chk
        p_masked_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !lane_mask[i]) |=>
            (vec_res[i*LANE_W +: LANE_W] == $past(dst_old[i*LANE_W +: LANE_W])));
    end
endmodule

// File: tb/sim_simd_vec_alu.sv
module sim_simd_vec_alu;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [3:0]   opcode = '0;
    logic [15:0]  lane_mask = '0;
    logic [511:0] src_a = '0, src_b = '0, src_c = '0, dst_old = '0;
    logic         out_valid;
    logic [511:0] vec_res;
    logic [31:0]  scal_res;
    logic         scan_zero;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    simd_vec_alu u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .lane_mask(lane_mask), .src_a(src_a), .src_b(src_b), .src_c(src_c),
        .dst_old(dst_old), .out_valid(out_valid), .vec_res(vec_res),
        .scal_res(scal_res), .scan_zero(scan_zero)
    );

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0: return "R2 R5";
            4'd1, 4'd2: return "R3 R5";
            4'd3: return "R4 R5";
            4'd4, 4'd5: return "R6";
            4'd6, 4'd7, 4'd8: return "R7";
            4'd9: return "R8";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [511:0] model_vec(input logic [3:0] op, input logic [15:0] m,
        input logic [511:0] a, input logic [511:0] b, input logic [511:0] c,
        input logic [511:0] old);
        logic [511:0] r;
        r = old;
        for (int i = 0; i < 16; i++) begin
            logic [63:0] full;
            logic [31:0] lo, cc;
            full = {32'd0, a[i*32 +: 32]} * {32'd0, b[i*32 +: 32]};
            lo = full[31:0];
            cc = c[i*32 +: 32];
            if (m[i] && op <= 4'd3) begin
                case (op)
                    4'd0: r[i*32 +: 32] = lo + cc;
                    4'd1: r[i*32 +: 32] = lo - cc;
                    4'd2: r[i*32 +: 32] = cc - lo;
                    default: r[i*32 +: 32] = 32'd1 - lo;
                endcase
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] model_scal(input logic [3:0] op, input logic [15:0] m,
        input logic [511:0] a);
        logic [31:0] acc;
        logic [63:0] p;
        case (op)
            4'd4: acc = 32'd0;
            4'd5: acc = 32'd1;
            4'd6: acc = 32'h7FFF_FFFF;
            4'd7: acc = 32'd0;
            4'd8: acc = 32'hFFFF_FFFF;
            default: acc = 32'd0;
        endcase
        if (op >= 4'd4 && op <= 4'd8) begin
            for (int i = 0; i < 16; i++) begin
                if (m[i]) begin
                    case (op)
                        4'd4: acc = acc + a[i*32 +: 32];
                        4'd5: begin
                            p = {32'd0, acc} * {32'd0, a[i*32 +: 32]};
                            acc = p[31:0];
                        end
                        4'd6: if (int'(a[i*32 +: 32]) < int'(acc)) acc = a[i*32 +: 32];
                        4'd7: acc = acc | a[i*32 +: 32];
                        default: acc = acc & a[i*32 +: 32];
                    endcase
                end
            end
        end else if (op == 4'd9) begin
            bit found;
            found = 1'b0;
            for (int i = 0; i < 32; i++) begin
                if (!found && a[i]) begin
                    acc = 32'(i);
                    found = 1'b1;
                end
            end
        end
        return acc;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // One request, result check, then one idle cycle with changed inputs.
    task automatic run(input logic [3:0] op, input logic [15:0] m,
                       input logic [511:0] a, input logic [511:0] b,
                       input logic [511:0] c, input logic [511:0] old);
        logic [511:0] ev, keep_v;
        logic [31:0]  es, keep_s;
        logic         ez, keep_z;
        ev = model_vec(op, m, a, b, c, old);
        es = model_scal(op, m, a);
        ez = (op == 4'd9) && (a[31:0] == 32'd0);
        @(negedge clk);
        opcode = op; lane_mask = m; src_a = a; src_b = b; src_c = c; dst_old = old;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1", "out_valid", {511'd0, out_valid}, 512'd1);
        chk(tag_of(op), "vec_res", vec_res, ev);
        chk(tag_of(op), "scal_res", {480'd0, scal_res}, {480'd0, es});
        chk("R8 R10", "scan_zero", {511'd0, scan_zero}, {511'd0, ez});
        keep_v = vec_res; keep_s = scal_res; keep_z = scan_zero;
        opcode = 4'($urandom); lane_mask = 16'($urandom);
        src_a = ~a; dst_old = ~old;
        @(negedge clk);
        chk("R1", "idle out_valid", {511'd0, out_valid}, 512'd0);
        chk("R11", "hold", {vec_res, scal_res, scan_zero} == {keep_v, keep_s, keep_z} ? 512'd1 : 512'd0, 512'd1);
    endtask

    function automatic logic [511:0] rand_vec();
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [511:0] fill(input logic [31:0] x);
        return {16{x}};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [511:0] ramp;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) ramp[i*32 +: 32] = 32'(i + 1);
        // R9: reset clears everything
        repeat (3) @(negedge clk);
        chk("R9", "reset out_valid", {511'd0, out_valid}, 512'd0);
        chk("R9", "reset vec_res", vec_res, 512'd0);
        chk("R9", "reset scal_res", {480'd0, scal_res}, 512'd0);
        chk("R9", "reset scan_zero", {511'd0, scan_zero}, 512'd0);
        rst_n = 1'b1;

        // Directed corner cases
        run(4'd0, 16'hFFFF, ramp, fill(32'd3), fill(32'd7), rand_vec());             // R2
        run(4'd0, 16'hFFFF, fill(32'h8000_0001), fill(32'd2), fill(32'hFFFF_FFFF), '0); // R2 wrap
        run(4'd1, 16'hA5A5, ramp, ramp, fill(32'd5), fill(32'hDEAD_BEEF));           // R3 R5
        run(4'd2, 16'h00FF, ramp, ramp, fill(32'd5), fill(32'h1234_5678));           // R3 R5
        run(4'd3, 16'hFFFF, ramp, fill(32'h1_0000), rand_vec(), '0);                 // R4
        run(4'd0, 16'h0000, rand_vec(), rand_vec(), rand_vec(), fill(32'hCAFE_F00D)); // R5 empty mask
        run(4'd4, 16'hFFFF, fill(32'hFFFF_FFFF), '0, '0, rand_vec());                // R6 sum wrap
        run(4'd5, 16'h000F, ramp, '0, '0, rand_vec());                               // R6 product 24
        run(4'd6, 16'hFFFF, {ramp[511:64], 32'hFFFF_FF00, 32'd5}, '0, '0, '0);        // R7 negative min
        run(4'd6, 16'h0000, ramp, '0, '0, '0);                                       // R7 min identity
        run(4'd8, 16'h0000, ramp, '0, '0, '0);                                       // R7 and identity
        run(4'd7, 16'h0006, ramp, '0, '0, '0);                                       // R7 or
        run(4'd9, 16'h0000, {480'd0, 32'h0000_0008}, '0, '0, '0);                    // R8 idx 3
        run(4'd9, 16'hFFFF, {480'd0, 32'h8000_0000}, '0, '0, '0);                    // R8 idx 31
        run(4'd9, 16'hFFFF, {{15{32'hFFFF_FFFF}}, 32'd0}, '0, '0, '0);                // R8 zero flag
        run(4'd12, 16'hFFFF, rand_vec(), rand_vec(), rand_vec(), rand_vec());        // R10

        // Constrained random mix
        for (int n = 0; n < 300; n++) begin
            logic [15:0] m;
            logic [511:0] a;
            case ($urandom % 4)
                0: m = 16'hFFFF;
                1: m = 16'h0000;
                default: m = 16'($urandom);
            endcase
            a = rand_vec();
            if ($urandom % 3 == 0) a[31:0] = 32'd1 << ($urandom % 32);
            run(4'($urandom), m, a, rand_vec(), rand_vec(), rand_vec());
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule